// File: doc/BRIEF.md
# Bus-Cycle Wait-State Controller

This block stretches the bus cycles of an 8-bit microprocessor by pulling its ready input low. At each cycle-start strobe it latches the status word that the processor places on the data bus. It arms a wait in two cases: when the cycle addresses the upper half of memory, which is where external modules sit, and when an interrupt is accepted. While the wait is in force, the processor holds its bus cycle.

A wait flip-flop is set by a reset-ready term and cleared by a set-ready term. Set-ready has three sources:

- an acknowledge from the external module, synchronized and then latched, combined with either the high address line or the interrupt-acknowledge status bit;
- a cycle-start strobe that coincides with the internal-interrupt indication;
- a missing-acknowledge timeout, so that a module that never answers cannot hang the processor.

Top module: `wait_state_ctrl`

## Requirements
- R1: When `cyc_start` is high at a rising clock edge, `stat_q` takes the value of `stat_bus` after that edge. At edges where `cyc_start` is low, `stat_q` keeps its value.
- R2: When `cyc_start` and `addr_hi` are both high at an edge while `ready` is high, `ready` is low after that edge.
- R3: An interrupt is taken when `irq` is high and `irq_en` is low, at the first edge where that combination holds. `ready` drops after that edge. Holding the combination for further edges does not arm the wait again.
- R4: `ext_ack` passes through two synchronizer flops and is then latched while a wait is in force. If `ext_ack` is first seen high at edge k of a wait, the latch is set at edge k+2. The wait then ends at edge k+3, provided `addr_hi` or bit 0 of `stat_q` (interrupt-acknowledge status) is high.
- R5: When `cyc_start` and `int_irq` are both high at an edge during a wait, `ready` is high after that edge.
- R6: If no acknowledge is latched, `ready` stays low for exactly `TIMEOUT_CYC` cycles after the wait is armed, and then returns high.
- R7: Once an acknowledge is latched, the timeout is suspended. The wait then lasts until one of the other two release paths ends it.
- R8: When a release and an arming condition occur at the same edge, the release wins and `ready` is high after that edge.
- R9: After reset, `ready` is high and `stat_q` is zero. The wait flop, the acknowledge latch and the timeout counter are all cleared.
- R10: An `ext_ack` pulse that arrives while no wait is in force is not kept. A later wait with no acknowledge still lasts the full `TIMEOUT_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_start | input | 1 | Cycle-start strobe from the processor |
| stat_bus | input | 6 | Status-word lines of the data bus |
| addr_hi | input | 1 | Address bit 15 (external module space) |
| irq | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt-enable from the processor |
| ext_ack | input | 1 | Asynchronous acknowledge from the external module |
| int_irq | input | 1 | Internal-interrupt indication |
| ready | output | 1 | Ready line to the processor; low means wait |
| stat_q | output | 6 | Latched status word |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 6 instead of the default 16. Because the timeout is short, a bench can count the full length of a wait that nobody acknowledges, cycle by cycle. It also makes it easy to hit the exact edge where the timeout fires at the same time as a new arming strobe. With the short limit, the synchronizer delay (three edges to release) is also clearly shorter than the timeout, so the acknowledge path can be told apart from expiry. Long random runs then reach many overlapping arm and release combinations.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int STAT_W   = 6;
  localparam int INTA_BIT = 0;

  typedef struct packed {
    logic expire;
    logic acked;
    logic intern;
  } release_t;
endpackage

// File: rtl/wsc_status_reg.sv
module wsc_status_reg #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] word_q
);
  logic [WIDTH-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en) word_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (word_q == $past(bus_in)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(word_q));
endmodule

// File: rtl/wsc_ack_track.sv
module wsc_ack_track #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic waiting,
  input  logic release_now,
  output logic ack_held
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              held_d;
  logic              ack_seen;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = ack_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], ack_in};
    end
  endgenerate

  assign ack_seen = sync_q[STAGES-1];

  always_comb begin
    held_d = 1'b0;
    if (waiting && !release_now) held_d = ack_held | ack_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      ack_held <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      ack_held <= held_d;
    end
  end

  assert_idle_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |=> !ack_held);
  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_held && waiting && !release_now) |=> ack_held);
endmodule

// File: rtl/wsc_timeout.sv
module wsc_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  input  logic clear,
  output logic fire
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign fire   = run && !hold && (cnt_q == LAST);
  assign cnt_en = run && !hold && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || clear)  cnt_d = '0;
    else if (cnt_en)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl #(
  parameter int TIMEOUT_CYC = 16,
  parameter int ACK_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cyc_start,
  input  logic [wsc_pkg::STAT_W-1:0] stat_bus,
  input  logic                       addr_hi,
  input  logic                       irq,
  input  logic                       irq_en,
  input  logic                       ext_ack,
  input  logic                       int_irq,
  output logic                       ready,
  output logic [wsc_pkg::STAT_W-1:0] stat_q
);
  import wsc_pkg::*;

  logic [1:0]  rst_pipe;
  logic        core_rst_n;
  logic        wait_q, wait_d;
  logic        take_q;
  logic        irq_cond;
  logic        irq_take;
  logic        rrdy;
  logic        srdy;
  logic        ack_held;
  logic        expire;
  release_t    rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  wsc_status_reg #(.WIDTH(STAT_W)) u_status (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cap_en (cyc_start),
    .bus_in (stat_bus),
    .word_q (stat_q)
  );

  assign irq_cond = irq && !irq_en;
  assign irq_take = irq_cond && !take_q;
  assign rrdy     = (cyc_start && addr_hi) || irq_take;

  always_comb begin
    rel.expire = expire;
    rel.acked  = wait_q && ack_held && (addr_hi || stat_q[INTA_BIT]);
    rel.intern = wait_q && cyc_start && int_irq;
  end
  assign srdy = |rel;

  wsc_ack_track #(.STAGES(ACK_STAGES)) u_ack (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .ack_in      (ext_ack),
    .waiting     (wait_q),
    .release_now (srdy),
    .ack_held    (ack_held)
  );

  wsc_timeout #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (wait_q),
    .hold  (ack_held),
    .clear (srdy),
    .fire  (expire)
  );

  always_comb begin
    wait_d = wait_q;
    if (srdy)      wait_d = 1'b0;
    else if (rrdy) wait_d = 1'b1;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wait_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      take_q <= irq_cond;
    end
  end

  assign ready = !wait_q;

  assert_ext_arm_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cyc_start && addr_hi && ready) |=> !ready);
  assert_irq_arm_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($rose(irq && !irq_en) && ready) |=> !ready);
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!ready && ack_held && (addr_hi || stat_q[INTA_BIT])) |=> ready);
  assert_int_release_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!ready && cyc_start && int_irq) |=> ready);
  assert_release_wins_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (srdy && rrdy) |=> ready);
  assert_reset_ready_R9: assert property (@(posedge clk)
    !core_rst_n |-> ready);
endmodule

// File: tb/wait_state_ctrl_test.sv
module wait_state_ctrl_test;
  localparam int TO = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_start, addr_hi, irq, irq_en, ext_ack, int_irq;
  logic [5:0] stat_bus;
  logic       ready;
  logic [5:0] stat_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit mdl_on = 1'b0;

  always #10 clk = ~clk;

  wait_state_ctrl #(.TIMEOUT_CYC(TO), .ACK_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .stat_bus(stat_bus),
    .addr_hi(addr_hi), .irq(irq), .irq_en(irq_en), .ext_ack(ext_ack),
    .int_irq(int_irq), .ready(ready), .stat_q(stat_q)
  );

  // reference model built from the requirements
  logic [5:0] m_stat;
  logic       m_wait, m_s1, m_s2, m_al, m_cd;
  int         m_cnt;

  function automatic bit m_srdy();
    bit tout, rack, rint;
    tout = m_wait && !m_al && (m_cnt == TO - 1);
    rack = m_wait && m_al && (addr_hi || m_stat[0]);
    rint = m_wait && cyc_start && int_irq;
    return tout || rack || rint;
  endfunction

  function automatic bit m_rrdy();
    return (cyc_start && addr_hi) || (irq && !irq_en && !m_cd);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_wait <= 0; m_s1 <= 0; m_s2 <= 0;
      m_al <= 0; m_cd <= 0; m_cnt <= 0;
    end else begin
      bit s, r;
      s = m_srdy();
      r = m_rrdy();
      if (cyc_start) m_stat <= stat_bus;
      m_wait <= s ? 1'b0 : (r ? 1'b1 : m_wait);
      m_al   <= (m_wait && !s) ? (m_al | m_s2) : 1'b0;
      m_cnt  <= (!m_wait || s) ? 0 : (m_al ? m_cnt : m_cnt + 1);
      m_s1   <= ext_ack;
      m_s2   <= m_s1;
      m_cd   <= irq && !irq_en;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mdl_on) begin
      chk("R1 model status", {2'b0, stat_q}, {2'b0, m_stat});
      chk("R2/R3/R4/R5/R6/R8 model ready", {7'b0, ready}, {7'b0, !m_wait});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    rst_n = 0; cyc_start = 0; addr_hi = 0; irq = 0; irq_en = 0;
    ext_ack = 0; int_irq = 0; stat_bus = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) tick();
    chk("R9 ready after reset", {7'b0, ready}, 8'h1);
    chk("R9 status after reset", {2'b0, stat_q}, 8'h0);
    mdl_on = 1;

    // R1 capture and hold
    cyc_start = 1; stat_bus = 6'h2A; tick();
    chk("R1 capture", {2'b0, stat_q}, 8'h2A);
    cyc_start = 0; stat_bus = 6'h15; tick();
    chk("R1 hold", {2'b0, stat_q}, 8'h2A);
    stat_bus = 0;

    // R2 arm, R6 full timeout
    cyc_start = 1; addr_hi = 1; tick();
    chk("R2 ready low", {7'b0, ready}, 8'h0);
    cyc_start = 0; addr_hi = 0;
    for (int n = 2; n <= TO; n++) begin
      tick();
      chk("R6 still waiting", {7'b0, ready}, 8'h0);
    end
    tick();
    chk("R6 timeout release", {7'b0, ready}, 8'h1);

    // R4 release by acknowledge with addr_hi
    cyc_start = 1; addr_hi = 1; tick();
    cyc_start = 0; ext_ack = 1;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R4 ack in flight", {7'b0, ready}, 8'h0);
    end
    tick();
    chk("R4 ack release", {7'b0, ready}, 8'h1);
    ext_ack = 0; addr_hi = 0;
    repeat (4) tick();

    // R7 latched ack suspends timeout, R5 internal release
    cyc_start = 1; addr_hi = 1; tick();
    cyc_start = 0; addr_hi = 0; ext_ack = 1; tick();
    ext_ack = 0;
    repeat (10) tick();
    chk("R7 wait beyond timeout", {7'b0, ready}, 8'h0);
    cyc_start = 1; int_irq = 1; tick();
    chk("R5 internal release", {7'b0, ready}, 8'h1);
    cyc_start = 0; int_irq = 0; tick();
    chk("R5 stays released", {7'b0, ready}, 8'h1);

    // R3 interrupt arm, R4 release via status bit 0
    cyc_start = 1; stat_bus = 6'h01; tick();
    cyc_start = 0; stat_bus = 0; irq = 1; irq_en = 1; tick();
    chk("R3 enabled irq no wait", {7'b0, ready}, 8'h1);
    irq_en = 0; tick();
    chk("R3 interrupt taken", {7'b0, ready}, 8'h0);
    ext_ack = 1;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R4 inta ack in flight", {7'b0, ready}, 8'h0);
    end
    tick();
    chk("R4 inta release", {7'b0, ready}, 8'h1);
    ext_ack = 0;
    for (int n = 0; n < 8; n++) begin
      tick();
      chk("R3 no re-arm", {7'b0, ready}, 8'h1);
    end
    irq = 0;
    cyc_start = 1; tick();
    cyc_start = 0; tick();

    // R8 release beats simultaneous arm
    cyc_start = 1; addr_hi = 1; tick();
    cyc_start = 0; addr_hi = 0;
    repeat (TO - 1) tick();
    cyc_start = 1; addr_hi = 1; tick();
    chk("R8 release wins", {7'b0, ready}, 8'h1);
    cyc_start = 0; addr_hi = 0; tick();
    chk("R8 no late arm", {7'b0, ready}, 8'h1);

    // R10 idle ack ignored
    ext_ack = 1; repeat (3) tick();
    ext_ack = 0; repeat (4) tick();
    cyc_start = 1; addr_hi = 1; tick();
    cyc_start = 0; addr_hi = 0;
    repeat (TO - 1) tick();
    chk("R10 full wait", {7'b0, ready}, 8'h0);
    tick();
    chk("R10 timeout end", {7'b0, ready}, 8'h1);

    // random phase, checked by the model
    for (int i = 0; i < 3000; i++) begin
      cyc_start = ($urandom % 4) == 0;
      addr_hi   = ($urandom % 3) == 0;
      irq       = ($urandom % 5) == 0;
      irq_en    = ($urandom % 2) == 0;
      ext_ack   = ($urandom % 6) == 0;
      int_irq   = ($urandom % 4) == 0;
      stat_bus  = 6'($urandom);
      tick();
    end
    finish_run();
  end
endmodule